// File: doc/BRIEF.md
# Pin Function Multiplexer with GPIO Register Bank

This block owns a large array of general-purpose pads grouped into lettered collections of eight pins. Software programs it over a plain synchronous byte bus. For each pin it keeps a two-bit function code, a drive-enable bit and an output-value bit. It also offers a read-only byte per collection that shows the synchronized pad levels.

The function code decides who drives the pad. Code zero leaves the pad with the local GPIO logic: the stored output value goes to the pad, gated by the stored drive enable. Codes one, two and three hand the pad's output and output enable to one of three peripheral client bundles. The pad level always goes to all three clients, whatever the code.

Software changes single fields by reading a byte, editing it and writing it back. Every write therefore replaces a whole byte, and every read returns the stored byte unchanged.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every function code, drive-enable bit and output-value bit is zero. Every pad then has output enable 0 and output 0, and every register reads 0.
- R2: Collection n (n = 0 .. NUM_GROUPS-1) occupies byte addresses BASE_ADDR + 8*n to BASE_ADDR + 8*n + 7, with BASE_ADDR = 0x20 by default. Pin number is 8*n plus the pin's position in the collection.
- R3: Offset 0 holds the function codes of positions 0 to 3, at bits [1:0], [3:2], [5:4] and [7:6] in that order. Offset 1 holds positions 4 to 7 at the same bit positions.
- R4: With function code 0, the pin's pad output equals its output-value bit (offset 3, bit = position) and its pad output enable equals its drive-enable bit (offset 2, bit = position; 1 = drive).
- R5: Function code 1, 2 or 3 routes client A, B or C respectively to the pad's output and output enable. The pin's drive-enable and output-value bits then have no effect on the pad.
- R6: A write to offset 0, 1, 2 or 3 replaces the whole byte with the write data. A later read of that address returns exactly that byte.
- R7: rd_data takes the addressed byte on the clock edge where rd_en is high, so it is visible in the following cycle. It holds its value while rd_en is low. The bench never raises wr_en and rd_en together.
- R8: Offset 6 is read-only. Bit k returns the level of that collection's pad at position k, as sampled two clock edges before the read is taken. The delay comes from a two-flop synchronizer.
- R9: Reads of offsets 4, 5 and 7, and of any address outside the mapped range, return 0. Writes to offsets 4, 5, 6 and 7, and to unmapped addresses, change no stored state.
- R10: client_in equals pad_in at all times, independent of any function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W (8) | Byte address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pad_in | input | NUM_GROUPS*8 (144) | Pad input levels |
| pad_out | output | NUM_GROUPS*8 (144) | Pad output values |
| pad_oe | output | NUM_GROUPS*8 (144) | Pad output enables |
| cli_a_out | input | NUM_GROUPS*8 (144) | Client A output values |
| cli_a_oe | input | NUM_GROUPS*8 (144) | Client A output enables |
| cli_b_out | input | NUM_GROUPS*8 (144) | Client B output values |
| cli_b_oe | input | NUM_GROUPS*8 (144) | Client B output enables |
| cli_c_out | input | NUM_GROUPS*8 (144) | Client C output values |
| cli_c_oe | input | NUM_GROUPS*8 (144) | Client C output enables |
| client_in | output | NUM_GROUPS*8 (144) | Pad levels forwarded to all clients |

## Verification
Some properties are checked on every cycle. A write replaces a stored byte. A write to the input byte leaves a collection's state alone. rd_data holds while no read is strobed, and unmapped reads return zero. The synchronized input lags the pads by exactly two edges. The packing of function codes into bits can only be shown by the bench scenarios, and so can the routing of each code to the right client, the masking of the GPIO bits under a client code, and the address decode at both ends of the range. The bench shows these by comparing the pads and the read data against its own model on every clock.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int PINS_PER_GROUP = 8;

  typedef enum logic [1:0] {
    FN_GPIO  = 2'd0,
    FN_CLI_A = 2'd1,
    FN_CLI_B = 2'd2,
    FN_CLI_C = 2'd3
  } pin_fn_e;

  localparam logic [2:0] OFS_SEL_LO = 3'd0;
  localparam logic [2:0] OFS_SEL_HI = 3'd1;
  localparam logic [2:0] OFS_DRIVE  = 3'd2;
  localparam logic [2:0] OFS_OUTV   = 3'd3;
  localparam logic [2:0] OFS_INPUT  = 3'd6;
endpackage

// File: rtl/pinmux_rst_sync.sv
module pinmux_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // cycles since reset, saturating at 2, so the check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/pinmux_group.sv
module pinmux_group
  import pinmux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [2:0]  ofs,
  input  logic [7:0]  wdata,
  input  logic [7:0]  in_sync,
  output logic [15:0] fn,
  output logic [7:0]  drive,
  output logic [7:0]  outv,
  output logic [7:0]  rbyte
);
  logic [7:0] sel_lo_q, sel_hi_q, drive_q, outv_q;
  logic       sel_lo_en, sel_hi_en, drive_en, outv_en;

  always_comb begin
    sel_lo_en = wr_hit && (ofs == OFS_SEL_LO);
    sel_hi_en = wr_hit && (ofs == OFS_SEL_HI);
    drive_en  = wr_hit && (ofs == OFS_DRIVE);
    outv_en   = wr_hit && (ofs == OFS_OUTV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      drive_q  <= '0;
      outv_q   <= '0;
    end else begin
      if (sel_lo_en) sel_lo_q <= wdata;
      if (sel_hi_en) sel_hi_q <= wdata;
      if (drive_en)  drive_q  <= wdata;
      if (outv_en)   outv_q   <= wdata;
    end
  end

  // position p uses bits [2p+1:2p] of {hi, lo}
  assign fn    = {sel_hi_q, sel_lo_q};
  assign drive = drive_q;
  assign outv  = outv_q;

  always_comb begin
    case (ofs)
      OFS_SEL_LO: rbyte = sel_lo_q;
      OFS_SEL_HI: rbyte = sel_hi_q;
      OFS_DRIVE:  rbyte = drive_q;
      OFS_OUTV:   rbyte = outv_q;
      OFS_INPUT:  rbyte = in_sync;
      default:    rbyte = 8'h00;
    endcase
  end

  assert_sel_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ofs == OFS_SEL_LO) |=> (fn[7:0] == $past(wdata)));

  assert_input_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ofs == OFS_INPUT) |=> $stable({fn, drive, outv}));
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
  import pinmux_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic [2*NPINS-1:0] fn,
  input  logic [NPINS-1:0]   gpio_drive,
  input  logic [NPINS-1:0]   gpio_outv,
  input  logic [NPINS-1:0]   cli_a_out,
  input  logic [NPINS-1:0]   cli_a_oe,
  input  logic [NPINS-1:0]   cli_b_out,
  input  logic [NPINS-1:0]   cli_b_oe,
  input  logic [NPINS-1:0]   cli_c_out,
  input  logic [NPINS-1:0]   cli_c_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_fn_e code;
    logic    po, pe;

    assign code = pin_fn_e'(fn[2*i +: 2]);

    always_comb begin
      case (code)
        FN_CLI_A: begin po = cli_a_out[i]; pe = cli_a_oe[i]; end
        FN_CLI_B: begin po = cli_b_out[i]; pe = cli_b_oe[i]; end
        FN_CLI_C: begin po = cli_c_out[i]; pe = cli_c_oe[i]; end
        default:  begin po = gpio_outv[i]; pe = gpio_drive[i]; end
      endcase
    end

    assign pad_out[i] = po;
    assign pad_oe[i]  = pe;
  end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_GROUPS = 18,
  parameter int BASE_ADDR  = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [7:0]                           wr_data,
  input  logic                                 wr_en,
  input  logic                                 rd_en,
  output logic [7:0]                           rd_data,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pad_in,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pad_out,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pad_oe,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_a_out,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_a_oe,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_b_out,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_b_oe,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_c_out,
  input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] cli_c_oe,
  output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] client_in
);
  localparam int NPINS = NUM_GROUPS * PINS_PER_GROUP;
  localparam int LIMIT = BASE_ADDR + NUM_GROUPS * 8;
  localparam int GRP_W = ADDR_W - 3;

  logic              rst_i_n;
  logic [ADDR_W-1:0] rel;
  logic [GRP_W-1:0]  grp_idx;
  logic [2:0]        ofs;
  logic              in_range;
  logic [NPINS-1:0]  in_sync;
  logic [2*NPINS-1:0] fn_all;
  logic [NPINS-1:0]  drive_all, outv_all;
  logic [7:0]        rbytes [NUM_GROUPS];
  logic [7:0]        rd_mux, rd_d, rd_q;

  pinmux_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  always_comb begin
    rel      = addr - ADDR_W'(BASE_ADDR);
    grp_idx  = rel[ADDR_W-1:3];
    ofs      = rel[2:0];
    in_range = (int'(addr) >= BASE_ADDR) && (int'(addr) < LIMIT);
  end

  pinmux_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(pad_in), .q(in_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && in_range && (grp_idx == GRP_W'(g));

    pinmux_group u_grp (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .wr_hit (hit),
      .ofs    (ofs),
      .wdata  (wr_data),
      .in_sync(in_sync[g*8 +: 8]),
      .fn     (fn_all[g*16 +: 16]),
      .drive  (drive_all[g*8 +: 8]),
      .outv   (outv_all[g*8 +: 8]),
      .rbyte  (rbytes[g])
    );
  end

  pinmux_route #(.NPINS(NPINS)) u_route (
    .fn        (fn_all),
    .gpio_drive(drive_all),
    .gpio_outv (outv_all),
    .cli_a_out (cli_a_out),
    .cli_a_oe  (cli_a_oe),
    .cli_b_out (cli_b_out),
    .cli_b_oe  (cli_b_oe),
    .cli_c_out (cli_c_out),
    .cli_c_oe  (cli_c_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  always_comb begin
    rd_mux = 8'h00;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_idx == GRP_W'(g)) rd_mux = rbytes[g];
    end
    rd_d = in_range ? rd_mux : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   rd_q <= 8'h00;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data   = rd_q;
  assign client_in = pad_in;

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_en |=> $stable(rd_data));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && !in_range) |=> (rd_data == 8'h00));
endmodule

// File: tb/test_pinmux_bank.sv
`timescale 1ns/1ps
module test_pinmux_bank;
  localparam int NG = 18;
  localparam int NP = NG * 8;
  localparam int BASE = 32;
  localparam int LIM = BASE + NG * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    addr, wr_data, rd_data;
  logic          wr_en, rd_en;
  logic [NP-1:0] pad_in, pad_out, pad_oe, client_in;
  logic [NP-1:0] a_out, a_oe, b_out, b_oe, c_out, c_oe;

  int total = 0;
  int bad   = 0;
  bit rand_on = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pinmux_bank i_pinmux_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .cli_a_out(a_out), .cli_a_oe(a_oe), .cli_b_out(b_out), .cli_b_oe(b_oe),
    .cli_c_out(c_out), .cli_c_oe(c_oe), .client_in(client_in)
  );

  // ---------------- reference model ----------------
  logic [1:0]    m_fn [NP];
  logic [NP-1:0] m_drv, m_out, h1, h2;
  logic [7:0]    exp_rd;

  function automatic logic [7:0] model_read(int a);
    logic [7:0] v = 8'h00;
    int g, o, pb;
    if (a < BASE || a >= LIM) return 8'h00;
    g = (a - BASE) / 8;
    o = (a - BASE) % 8;
    pb = g * 8;
    case (o)
      0: for (int p = 0; p < 4; p++) v[2*p +: 2] = m_fn[pb + p];
      1: for (int p = 0; p < 4; p++) v[2*p +: 2] = m_fn[pb + 4 + p];
      2: v = m_drv[pb +: 8];
      3: v = m_out[pb +: 8];
      6: v = h2[pb +: 8];
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic model_write(int a, logic [7:0] d);
    int g, o, pb;
    if (a < BASE || a >= LIM) return;
    g = (a - BASE) / 8;
    o = (a - BASE) % 8;
    pb = g * 8;
    case (o)
      0: for (int p = 0; p < 4; p++) m_fn[pb + p] = d[2*p +: 2];
      1: for (int p = 0; p < 4; p++) m_fn[pb + 4 + p] = d[2*p +: 2];
      2: m_drv[pb +: 8] = d;
      3: m_out[pb +: 8] = d;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_fn[i] = 2'd0;
      m_drv = '0; m_out = '0; h1 = '0; h2 = '0; exp_rd = 8'h00;
    end else begin
      if (rd_en) exp_rd = model_read(int'(addr));
      if (wr_en) model_write(int'(addr), wr_data);
      h2 = h1;
      h1 = pad_in;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [NP-1:0] eo, ee;
    #1;
    if (rst_n && !finished) begin
      for (int i = 0; i < NP; i++) begin
        case (m_fn[i])
          2'd1: begin eo[i] = a_out[i]; ee[i] = a_oe[i]; end
          2'd2: begin eo[i] = b_out[i]; ee[i] = b_oe[i]; end
          2'd3: begin eo[i] = c_out[i]; ee[i] = c_oe[i]; end
          default: begin eo[i] = m_out[i]; ee[i] = m_drv[i]; end
        endcase
      end
      total++;
      if (pad_out !== eo || pad_oe !== ee) begin
        bad++;
        $display("FAIL R4/R5 pad routing: out=%h oe=%h expected out=%h oe=%h",
                 pad_out, pad_oe, eo, ee);
      end
      total++;
      if (rd_data !== exp_rd) begin
        bad++;
        $display("FAIL R6 model read: got %h expected %h", rd_data, exp_rd);
      end
      total++;
      if (client_in !== pad_in) begin
        bad++;
        $display("FAIL R10 client_in: got %h expected %h", client_in, pad_in);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [NP-1:0] rnd();
    logic [NP-1:0] v;
    logic [31:0] r;
    for (int i = 0; i < NP; i++) begin r = $urandom(); v[i] = r[0]; end
    return v;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rand_on) begin
        pad_in = rnd(); a_out = rnd(); a_oe = rnd();
        b_out = rnd(); b_oe = rnd(); c_out = rnd(); c_oe = rnd();
      end
    end
  end

  task automatic check1(string tag, logic [31:0] got, logic [31:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 8'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [7:0] e, string tag);
    @(negedge clk);
    addr = 8'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check1(tag, 32'(rd_data), 32'(e));
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got hung expected done");
    summary();
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] held;
    logic [31:0] r;
    rst_n = 1'b0; addr = '0; wr_data = '0; wr_en = 0; rd_en = 0;
    pad_in = '0; a_out = '0; a_oe = '0; b_out = '0; b_oe = '0; c_out = '0; c_oe = '0;
    repeat (3) @(negedge clk);
    #1;
    check1("R1 pad_oe in reset", 32'(pad_oe == '0), 32'd1);
    check1("R1 pad_out in reset", 32'(pad_out == '0), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 registers read zero
    for (int o = 0; o < 4; o++) rd_chk(BASE + o, 8'h00, "R1 group0 reset read");
    rd_chk(BASE + 17*8, 8'h00, "R1 last group reset read");
    rd_chk(BASE + 6, 8'h00, "R1 input reset read");

    // fixed client bundles
    @(negedge clk);
    a_out = '0; a_oe = '1; b_out = '1; b_oe = '0; c_out = '1; c_oe = '1;

    // R3 packing and R6 full-byte replacement
    wr(BASE, 8'hE4);                    // pos0..3 = 0,1,2,3
    rd_chk(BASE, 8'hE4, "R6 readback offset0");
    #1;
    check1("R3 pos1 client A oe", 32'(pad_oe[1]), 32'd1);
    check1("R3 pos2 client B oe", 32'(pad_oe[2]), 32'd0);
    check1("R3 pos3 client C out", 32'(pad_out[3]), 32'd1);
    check1("R4 pos0 gpio input", 32'(pad_oe[0]), 32'd0);
    wr(BASE + 1, 8'h40);                // pos7 = client A
    #1;
    check1("R3 pos7 client A oe", 32'(pad_oe[7]), 32'd1);
    check1("R3 pos4 still gpio", 32'(pad_oe[4]), 32'd0);
    wr(BASE + 2*8, 8'h0C);              // group2 pos1 (pin 17) = client C
    #1;
    check1("R2 pin17 client C oe", 32'(pad_oe[17]), 32'd1);
    check1("R2 pin17 client C out", 32'(pad_out[17]), 32'd1);
    check1("R2 pin16 stays gpio", 32'(pad_oe[16]), 32'd0);

    // R4 GPIO drive and value
    wr(BASE + 8 + 2, 8'hA5);
    wr(BASE + 8 + 3, 8'h0F);
    #1;
    check1("R4 pin8 oe", 32'(pad_oe[8]), 32'd1);
    check1("R4 pin8 out", 32'(pad_out[8]), 32'd1);
    check1("R4 pin9 oe", 32'(pad_oe[9]), 32'd0);
    check1("R4 pin13 oe", 32'(pad_oe[13]), 32'd1);
    check1("R4 pin13 out", 32'(pad_out[13]), 32'd0);
    rd_chk(BASE + 8 + 2, 8'hA5, "R6 readback drive");

    // R5 GPIO bits masked under client code
    wr(BASE + 2, 8'h00);
    wr(BASE + 3, 8'hFF);
    #1;
    check1("R5 pin1 ignores gpio out", 32'(pad_out[1]), 32'd0);
    check1("R5 pin1 ignores gpio drive", 32'(pad_oe[1]), 32'd1);
    wr(BASE, 8'h00);
    #1;
    check1("R4 pin1 back to gpio oe", 32'(pad_oe[1]), 32'd0);
    check1("R4 pin1 back to gpio out", 32'(pad_out[1]), 32'd1);

    // R9 holes and unmapped space
    rd_chk(BASE + 4, 8'h00, "R9 offset4 read");
    wr(BASE + 4, 8'hFF);
    rd_chk(BASE + 4, 8'h00, "R9 offset4 after write");
    wr(BASE + 5, 8'hFF);
    wr(BASE + 7, 8'hFF);
    rd_chk(BASE + 3, 8'hFF, "R9 neighbour unchanged");
    rd_chk(BASE - 1, 8'h00, "R9 below range");
    rd_chk(LIM, 8'h00, "R9 above range");
    rd_chk(255, 8'h00, "R9 top address");
    wr(LIM, 8'hFF);
    rd_chk(LIM - 8, 8'h00, "R9 last group untouched by unmapped write");
    #1;
    check1("R9 last group oe", 32'(pad_oe[NP-8 +: 8]), 32'd0);

    // R8 synchronizer latency and read-only input
    @(negedge clk);
    pad_in[7:0] = 8'h5A;
    repeat (3) @(negedge clk);
    rd_chk(BASE + 6, 8'h5A, "R8 input level");
    wr(BASE + 6, 8'h00);
    rd_chk(BASE + 6, 8'h5A, "R9 input write ignored");
    @(negedge clk);
    pad_in[7:0] = 8'hC3;
    addr = 8'(BASE + 6); rd_en = 1'b1;
    @(negedge clk); #1;
    check1("R8 one edge old", 32'(rd_data), 32'h5A);
    @(negedge clk); #1;
    check1("R8 two edges old", 32'(rd_data), 32'h5A);
    @(negedge clk); #1;
    check1("R8 new level", 32'(rd_data), 32'hC3);
    rd_en = 1'b0;
    check1("R10 client_in follows pad", 32'(client_in[7:0]), 32'hC3);

    // R7 hold while idle
    held = rd_data;
    @(negedge clk);
    addr = 8'(BASE + 3);
    repeat (3) @(negedge clk);
    #1;
    check1("R7 rd_data held", 32'(rd_data), 32'(held));

    // random traffic against the model
    rand_on = 1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      r = $urandom();
      addr = 8'(r[7:0] % 8'd192);
      wr_data = r[15:8];
      wr_en = (r[17:16] == 2'd0) || (r[17:16] == 2'd1 && r[18]);
      rd_en = !wr_en && r[17:16] != 2'd3;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    #2;
    summary();
  end
endmodule